// File: doc/BRIEF.md
# Latency-Delayed Trigger Sequencer

This block turns accepted trigger pulses into serial command patterns on two single-bit lines. The front-end line carries three command kinds: a one-bit trigger (`1`), a three-bit calibration pattern (`1,1,0`) and a three-bit reset pattern (`1,0,1`). Each kind has its own 16-bit latency and is scheduled independently. The readout line carries a plain trigger bit with its own latency. Two software strobes request an immediate reset pattern on both lines at once.

Each scheduled command sits in a small per-kind queue. An entry records the due time, which is the value of a free-running cycle counter plus the latency sampled when the trigger arrived. Several triggers can therefore be outstanding within one latency window. Each line has a serializer that emits one pattern at a time. A pattern already in progress always finishes. When several commands are due together, the serializer picks by a fixed priority.

Top module: `trig_sequencer`

## Requirements
- R1: A trigger sampled high at clock edge E puts a `1` on `fe_line` during the cycle that starts at edge E+`fe_lat`, for `fe_lat` from 1 to 65535, when the line is free.
- R2: When `cal_en` is 1 at the trigger's sampling edge, the pattern 1,1,0 (first bit first) starts on `fe_line` at edge E+`cal_lat`. When `cal_en` is 0, no calibration pattern is produced.
- R3: When `rst_en` is 1 at the trigger's sampling edge, the pattern 1,0,1 starts on `fe_line` at edge E+`rst_lat`. When `rst_en` is 0, no reset pattern is produced.
- R4: A trigger sampled at edge E puts a `1` on `ro_line` during the cycle that starts at edge E+`ro_lat`, for `ro_lat` from 1 to 65535.
- R5: A high `soft_fe_rst` or `soft_ro_rst` sampled at edge E starts the pattern 1,0,1 on both `fe_line` and `ro_line` at edge E. If a line is busy, the pattern starts at the first edge after that line's current pattern ends.
- R6: Each queue holds up to 8 pending commands, so up to 8 triggers can be in flight per command kind. A trigger that arrives while a queue holds 8 pending entries is discarded for that kind and produces no output.
- R7: The latency applied to a trigger is the register value at the trigger's sampling edge. Later writes do not move commands already queued.
- R8: A pattern in progress on a line is never cut off. When commands are due together, the order is software reset, then delayed reset, then calibration, then trigger. The waiting commands follow back to back.
- R9: During and right after reset both lines are 0 and no command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Accepted trigger pulse, one cycle per trigger |
| fe_lat | input | 16 | Front-end trigger latency in clocks |
| cal_lat | input | 16 | Calibration pattern latency in clocks |
| rst_lat | input | 16 | Reset pattern latency in clocks |
| ro_lat | input | 16 | Readout trigger latency in clocks |
| cal_en | input | 1 | Enables the calibration pattern per trigger |
| rst_en | input | 1 | Enables the delayed reset pattern per trigger |
| soft_fe_rst | input | 1 | Software front-end reset strobe |
| soft_ro_rst | input | 1 | Software readout reset strobe |
| fe_line | output | 1 | Serial front-end command line |
| ro_line | output | 1 | Serial readout trigger line |

## Verification
A corrupted due time or a lost ripe flag shows up as a missing or shifted bit on a line. It appears at the exact cycle the trigger's latency names, so each check compares a whole cycle-indexed window of both lines against a mask computed from the latencies. A fault in arbitration or in the serializer's bit count shows within three cycles of the collision, as a truncated or merged pattern. The priority, in-progress and depth-limit tests are built to provoke those collisions directly.

// File: rtl/seq_pkg.sv
package seq_pkg;
   localparam int unsigned PAT_W = 3;
   localparam int unsigned LEN_W = 2;
   // patterns are emitted from the most significant bit down
   localparam logic [PAT_W-1:0] PAT_TRIG = 3'b100;
   localparam logic [PAT_W-1:0] PAT_CAL  = 3'b110;
   localparam logic [PAT_W-1:0] PAT_RST  = 3'b101;
   localparam logic [LEN_W-1:0] LEN_TRIG = 2'd1;
   localparam logic [LEN_W-1:0] LEN_CAL  = 2'd3;
   localparam logic [LEN_W-1:0] LEN_RST  = 2'd3;
endpackage

// File: rtl/seq_lat_queue.sv
module seq_lat_queue #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] now,
   input  logic             push,
   input  logic [CNT_W-1:0] lat,
   output logic             due,
   input  logic             pop
);
   logic [DEPTH-1:0] valid, ripe, match, ready, free_sel, pop_sel;
   logic [CNT_W-1:0] when_q [DEPTH];

   initial begin
      assert (DEPTH >= 1) else $error("seq_lat_queue: DEPTH must be at least 1");
      assert (CNT_W >= 2) else $error("seq_lat_queue: CNT_W must be at least 2");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign match[i] = valid[i] && (when_q[i] == now);
      assign ready[i] = valid[i] && (ripe[i] || match[i]);
   end

   always_comb begin
      logic got_free, got_pop;
      free_sel = '0;
      pop_sel  = '0;
      got_free = 1'b0;
      got_pop  = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!valid[i] && !got_free) begin
            free_sel[i] = 1'b1;
            got_free    = 1'b1;
         end
         if (ready[i] && !got_pop) begin
            pop_sel[i] = 1'b1;
            got_pop    = 1'b1;
         end
      end
   end

   assign due = |ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= '0;
         ripe  <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (pop && pop_sel[i]) begin
               valid[i] <= 1'b0;
               ripe[i]  <= 1'b0;
            end else if (push && free_sel[i]) begin
               valid[i] <= 1'b1;
               ripe[i]  <= 1'b0;
            end else if (match[i]) begin
               ripe[i]  <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (push && free_sel[i]) when_q[i] <= now + lat;
      end
   end

   // R6
   pop_needs_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> due);
   // R8
   due_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (due && !pop) |=> due);
endmodule

// File: rtl/seq_line.sv
module seq_line #(
   parameter int unsigned NSRC = 2,
   parameter logic [NSRC*seq_pkg::PAT_W-1:0] PATS = '0,
   parameter logic [NSRC*seq_pkg::LEN_W-1:0] LENS = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req,
   output logic [NSRC-1:0] grant,
   output logic            line
);
   import seq_pkg::*;

   logic [LEN_W-1:0] left;
   logic [PAT_W-1:0] sh;
   logic             line_q;
   logic [PAT_W-1:0] sel_pat;
   logic [LEN_W-1:0] sel_len;
   logic             idle;

   initial begin
      assert (NSRC >= 1) else $error("seq_line: NSRC must be at least 1");
   end

   assign idle = (left == '0);

   always_comb begin
      logic taken;
      grant   = '0;
      sel_pat = '0;
      sel_len = '0;
      taken   = 1'b0;
      if (idle) begin
         for (int s = 0; s < NSRC; s++) begin
            if (req[s] && !taken) begin
               grant[s] = 1'b1;
               sel_pat  = PATS[s*PAT_W +: PAT_W];
               sel_len  = LENS[s*LEN_W +: LEN_W];
               taken    = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left   <= '0;
         sh     <= '0;
         line_q <= 1'b0;
      end else if (|grant) begin
         line_q <= sel_pat[PAT_W-1];
         sh     <= {sel_pat[PAT_W-2:0], 1'b0};
         left   <= sel_len - LEN_W'(1);
      end else if (!idle) begin
         line_q <= sh[PAT_W-1];
         sh     <= {sh[PAT_W-2:0], 1'b0};
         left   <= left - LEN_W'(1);
      end else begin
         line_q <= 1'b0;
      end
   end

   assign line = line_q;

   // R8
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   for (genvar s = 0; s < NSRC; s++) begin : g_shape
      localparam logic [PAT_W-1:0] P = PATS[s*PAT_W +: PAT_W];
      localparam logic [LEN_W-1:0] L = LENS[s*LEN_W +: LEN_W];
      if (L == 2'd3) begin : g_three
         // R2 R3 R5
         pattern_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant[s] |=> (line == P[2]) ##1 (line == P[1]) ##1 (line == P[0]));
      end else begin : g_one
         // R1 R4
         pattern_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant[s] |=> (line == P[2]));
      end
   end
endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned QDEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_in,
   input  logic [CNT_W-1:0] fe_lat,
   input  logic [CNT_W-1:0] cal_lat,
   input  logic [CNT_W-1:0] rst_lat,
   input  logic [CNT_W-1:0] ro_lat,
   input  logic             cal_en,
   input  logic             rst_en,
   input  logic             soft_fe_rst,
   input  logic             soft_ro_rst,
   output logic             fe_line,
   output logic             ro_line
);
   import seq_pkg::*;

   localparam int unsigned NQ    = 4;
   localparam int unsigned Q_FE  = 0;
   localparam int unsigned Q_CAL = 1;
   localparam int unsigned Q_RST = 2;
   localparam int unsigned Q_RO  = 3;
   localparam int unsigned FE_N  = 4;
   localparam int unsigned RO_N  = 2;
   // source 0 has the highest priority
   localparam logic [FE_N*PAT_W-1:0] FE_PATS = {PAT_TRIG, PAT_CAL, PAT_RST, PAT_RST};
   localparam logic [FE_N*LEN_W-1:0] FE_LENS = {LEN_TRIG, LEN_CAL, LEN_RST, LEN_RST};
   localparam logic [RO_N*PAT_W-1:0] RO_PATS = {PAT_TRIG, PAT_RST};
   localparam logic [RO_N*LEN_W-1:0] RO_LENS = {LEN_TRIG, LEN_RST};

   logic [CNT_W-1:0] now;
   logic [NQ-1:0]    q_push, q_due, q_pop;
   logic [CNT_W-1:0] q_lat [NQ];
   logic [FE_N-1:0]  fe_req, fe_grant;
   logic [RO_N-1:0]  ro_req, ro_grant;
   logic             soft_any, pend_fe, pend_ro;

   always_ff @(posedge clk) begin
      if (!rst_n) now <= '0;
      else        now <= now + CNT_W'(1);
   end

   always_comb begin
      q_push[Q_FE]  = trig_in;
      q_push[Q_CAL] = trig_in && cal_en;
      q_push[Q_RST] = trig_in && rst_en;
      q_push[Q_RO]  = trig_in;
      q_lat[Q_FE]   = fe_lat;
      q_lat[Q_CAL]  = cal_lat;
      q_lat[Q_RST]  = rst_lat;
      q_lat[Q_RO]   = ro_lat;
   end

   for (genvar q = 0; q < NQ; q++) begin : g_q
      seq_lat_queue #(.DEPTH(QDEPTH), .CNT_W(CNT_W)) u_q (
         .clk  (clk),
         .rst_n(rst_n),
         .now  (now),
         .push (q_push[q]),
         .lat  (q_lat[q]),
         .due  (q_due[q]),
         .pop  (q_pop[q])
      );
   end

   assign soft_any = soft_fe_rst | soft_ro_rst;
   assign fe_req   = {q_due[Q_FE], q_due[Q_CAL], q_due[Q_RST], soft_any | pend_fe};
   assign ro_req   = {q_due[Q_RO], soft_any | pend_ro};

   assign q_pop[Q_RST] = fe_grant[1];
   assign q_pop[Q_CAL] = fe_grant[2];
   assign q_pop[Q_FE]  = fe_grant[3];
   assign q_pop[Q_RO]  = ro_grant[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_fe <= 1'b0;
         pend_ro <= 1'b0;
      end else begin
         pend_fe <= (soft_any | pend_fe) && !fe_grant[0];
         pend_ro <= (soft_any | pend_ro) && !ro_grant[0];
      end
   end

   seq_line #(.NSRC(FE_N), .PATS(FE_PATS), .LENS(FE_LENS)) u_fe (
      .clk(clk), .rst_n(rst_n), .req(fe_req), .grant(fe_grant), .line(fe_line));

   seq_line #(.NSRC(RO_N), .PATS(RO_PATS), .LENS(RO_LENS)) u_ro (
      .clk(clk), .rst_n(rst_n), .req(ro_req), .grant(ro_grant), .line(ro_line));

   // R5
   soft_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_fe |-> !fe_grant[3] && !fe_grant[2] && !fe_grant[1]);
endmodule

// File: tb/sim_trig_sequencer.sv
module sim_trig_sequencer;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        trig_in, cal_en, rst_en, soft_fe_rst, soft_ro_rst;
   logic [15:0] fe_lat, cal_lat, rst_lat, ro_lat;
   logic        fe_line, ro_line;

   int total = 0;
   int fails = 0;
   int chg_at = -1;
   logic [15:0] fe_next = 16'd1;
   bit done = 1'b0;

   always #10 clk = ~clk;

   trig_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
      .fe_lat(fe_lat), .cal_lat(cal_lat), .rst_lat(rst_lat), .ro_lat(ro_lat),
      .cal_en(cal_en), .rst_en(rst_en),
      .soft_fe_rst(soft_fe_rst), .soft_ro_rst(soft_ro_rst),
      .fe_line(fe_line), .ro_line(ro_line));

   // {fe_lat, cal_lat, rst_lat, ro_lat, cal_en, rst_en}, one trigger at cycle 0
   localparam int NV = 6;
   localparam logic [65:0] VEC [NV] = '{
      {16'd1,  16'd5,  16'd10, 16'd1,  1'b1, 1'b1},
      {16'd20, 16'd3,  16'd8,  16'd30, 1'b1, 1'b1},
      {16'd7,  16'd3,  16'd12, 16'd15, 1'b0, 1'b0},
      {16'd2,  16'd10, 16'd4,  16'd2,  1'b0, 1'b1},
      {16'd25, 16'd30, 16'd34, 16'd39, 1'b1, 1'b0},
      {16'd40, 16'd12, 16'd20, 16'd44, 1'b1, 1'b1}
   };
   localparam int WIN = 48;

   function automatic logic [63:0] b(input int p);
      return 64'd1 << p;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic set_lat(input int f, input int c, input int r, input int o,
                          input logic ce, input logic re);
      fe_lat = 16'(f); cal_lat = 16'(c); rst_lat = 16'(r); ro_lat = 16'(o);
      cal_en = ce; rst_en = re;
   endtask

   task automatic run(input logic [63:0] tmask, input logic [63:0] sfe,
                      input logic [63:0] sro, input logic [63:0] exp_fe,
                      input logic [63:0] exp_ro, input string req);
      logic [63:0] got_fe = '0;
      logic [63:0] got_ro = '0;
      for (int k = 0; k < WIN; k++) begin
         trig_in = tmask[k];
         soft_fe_rst = sfe[k];
         soft_ro_rst = sro[k];
         if (k == chg_at) fe_lat = fe_next;
         @(posedge clk);
         @(negedge clk);
         got_fe[k] = fe_line;
         got_ro[k] = ro_line;
      end
      trig_in = 1'b0; soft_fe_rst = 1'b0; soft_ro_rst = 1'b0;
      chg_at = -1;
      chk(got_fe == exp_fe, req, "fe_line window", got_fe, exp_fe);
      chk(got_ro == exp_ro, req, "ro_line window", got_ro, exp_ro);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [63:0] ef, er;
      int first_fe, first_ro, n_fe, n_ro;
      rst_n = 1'b0; trig_in = 1'b0; soft_fe_rst = 1'b0; soft_ro_rst = 1'b0;
      set_lat(1, 1, 1, 1, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      // R9 lines low in reset
      chk(fe_line == 1'b0 && ro_line == 1'b0, "R9", "lines during reset",
          {62'd0, fe_line, ro_line}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(fe_line == 1'b0 && ro_line == 1'b0, "R9", "lines after reset",
          {62'd0, fe_line, ro_line}, 64'd0);

      // R1 R2 R3 R4 table walk
      for (int v = 0; v < NV; v++) begin
         set_lat(int'(VEC[v][65:50]), int'(VEC[v][49:34]), int'(VEC[v][33:18]),
                 int'(VEC[v][17:2]), VEC[v][1], VEC[v][0]);
         ef = b(int'(fe_lat));
         if (cal_en) ef |= b(int'(cal_lat)) | b(int'(cal_lat) + 1);
         if (rst_en) ef |= b(int'(rst_lat)) | b(int'(rst_lat) + 2);
         er = b(int'(ro_lat));
         run(64'd1, '0, '0, ef, er, "R1 R2 R3 R4");
      end

      // R8 simultaneous: reset, then calibration, then trigger
      set_lat(5, 5, 5, 9, 1'b1, 1'b1);
      run(64'd1, '0, '0, b(5) | b(7) | b(8) | b(9) | b(11), b(9), "R8 priority");

      // R8 pattern in progress finishes before a due reset
      set_lat(20, 3, 4, 20, 1'b1, 1'b1);
      run(64'd1, '0, '0, b(3) | b(4) | b(6) | b(8) | b(20), b(20), "R8 no preempt");

      // R6 several triggers in flight
      set_lat(10, 1, 1, 12, 1'b0, 1'b0);
      run(b(0) | b(2) | b(5), '0, '0, b(10) | b(12) | b(15),
          b(12) | b(14) | b(17), "R6 in flight");

      // R7 latency captured at enqueue
      set_lat(10, 1, 1, 30, 1'b0, 1'b0);
      chg_at = 1; fe_next = 16'd3;
      run(b(0) | b(4), '0, '0, b(10) | b(7), b(30) | b(34), "R7 latency capture");

      // R6 ninth trigger discarded while eight are pending
      set_lat(20, 1, 1, 20, 1'b0, 1'b0);
      run(64'h1FF, '0, '0, 64'hFF << 20, 64'hFF << 20, "R6 depth limit");

      // R5 software strobes on idle lines
      set_lat(40, 1, 1, 40, 1'b0, 1'b0);
      run('0, b(2), b(10), b(2) | b(4) | b(10) | b(12), b(2) | b(4) | b(10) | b(12),
          "R5 soft reset");

      // R5 R8 soft reset waits for calibration in progress
      set_lat(15, 3, 1, 20, 1'b1, 1'b0);
      run(64'd1, b(4), '0, b(3) | b(4) | b(6) | b(8) | b(15), b(4) | b(6) | b(20),
          "R5 R8 soft while busy");

      // R1 R4 largest latencies
      set_lat(65535, 1, 1, 65534, 1'b0, 1'b0);
      first_fe = -1; first_ro = -1; n_fe = 0; n_ro = 0;
      trig_in = 1'b1;
      @(posedge clk);
      @(negedge clk);
      trig_in = 1'b0;
      for (int k = 1; k <= 65540; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (fe_line) begin n_fe++; if (first_fe < 0) first_fe = k; end
         if (ro_line) begin n_ro++; if (first_ro < 0) first_ro = k; end
      end
      chk(first_fe == 65535 && n_fe == 1, "R1", "max fe latency cycle",
          64'(first_fe), 64'd65535);
      chk(first_ro == 65534 && n_ro == 1, "R4", "max ro latency cycle",
          64'(first_ro), 64'd65534);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule